// File: doc/BRIEF.md
# Nibble Scratch Register Bank

This block holds four 4-bit registers that a CPU reads and writes through a 2 KB window at $5800-$5FFF of its address space. A multi-game cartridge menu stores the last selected game here. A console reset then returns to the menu with that entry still highlighted. Only the two lowest address bits select a register, so each register repeats every four bytes across the window.

Writes are taken on the falling edge of the bus phase clock M2, which the block samples with its own system clock. Only the low data nibble is kept. Reads drive the selected nibble onto a 4-bit output together with an output-enable flag. Two resets exist. The power-on reset fills every register with $F. The console reset keeps the contents and only blocks bus access while it is held.

Top module: `nib_scratch`

## Requirements
- R1: An access takes effect only when addr_i[15:11] equals 5'b01011, which is $5800-$5FFF. A write outside the window changes no register, and a read outside it keeps rd_oe_o low.
- R2: addr_i[1:0] selects register 0 to 3. addr_i[10:2] have no effect, so $5800, $5804 and $5FFC all reach register 0.
- R3: A write stores wdata_i[3:0] into the selected register. wdata_i[7:4] are discarded, and the other three registers keep their values.
- R4: A write happens only on the system-clock edge at which m2_i is first seen low after being high, and only if rw_i is 0 at that edge. Holding m2_i high, or letting it fall while rw_i is 1, stores nothing.
- R5: While m2_i is 1, rw_i is 1 and the address is in the window, rd_oe_o is 1 and rdata_o carries the selected nibble. Otherwise rd_oe_o is 0 and rdata_o is 0.
- R6: When the asynchronous power-on reset rst_ni is low, all four registers become $F.
- R7: When con_rst_ni is low, no register changes and rd_oe_o stays 0. The contents are still there after con_rst_ni returns high.
- R8: Reading has no side effect, so repeated reads return the same nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| con_rst_ni | input | 1 | Console reset, active low; contents kept |
| m2_i | input | 1 | CPU bus phase clock |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 4 | Selected nibble during a window read |
| rd_oe_o | output | 1 | Read data valid / bus drive enable |

## Verification
Assertions check on every cycle that:
- only one register can be written at a time;
- a written register takes the low nibble of the bus;
- registers that are not written keep their value;
- rd_oe_o only rises on a read inside the window;
- console reset freezes the bank.

The bench scenarios cover the rest: aliasing across the window, rejected writes just outside it, the falling-edge capture rule when rw_i changes while M2 is high, the $F power-on state, and contents that remain after a console reset.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int NUM_REGS = 4;
  localparam int WIN_LOG2 = 11;
  localparam logic [ADDR_W-1:0] WIN_BASE = 16'h5800;
endpackage

// File: rtl/nib_win_dec.sv
module nib_win_dec #(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 11,
  parameter int SEL_W    = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h5800
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic unused_mid;

  assign in_win_o   = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign sel_o      = addr_i[SEL_W-1:0];
  // alias bits between selector and window tag are don't-care
  assign unused_mid = ^addr_i[WIN_LOG2-1:SEL_W];
endmodule

// File: rtl/nib_m2_edge.sv
module nib_m2_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic m2_i,
  output logic fall_o
);
  logic m2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  assign fall_o = m2_q & ~m2_i;
endmodule

// File: rtl/nib_bank.sv
module nib_bank #(
  parameter int NUM_REGS = 4,
  parameter int NIB_W    = 4,
  parameter logic [NIB_W-1:0] INIT_VAL = '1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_REGS-1:0]             we_i,
  input  logic [NIB_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][NIB_W-1:0]  q_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[g] <= INIT_VAL;
      else if (we_i[g]) q_o[g] <= wdata_i;
    end

    assert_write_nibble_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[g] |=> q_o[g] == $past(wdata_i));

    assert_hold_unselected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[g] |=> $stable(q_o[g]));
  end

  assert_one_hot_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i));
endmodule

// File: rtl/nib_scratch.sv
module nib_scratch
  import nib_pkg::*;
#(
  parameter int ADDR_W_P   = ADDR_W,
  parameter int DATA_W_P   = DATA_W,
  parameter int NIB_W_P    = NIB_W,
  parameter int NUM_REGS_P = NUM_REGS,
  parameter int WIN_LOG2_P = WIN_LOG2,
  parameter logic [ADDR_W_P-1:0] WIN_BASE_P = WIN_BASE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                con_rst_ni,
  input  logic                m2_i,
  input  logic                rw_i,
  input  logic [ADDR_W_P-1:0] addr_i,
  input  logic [DATA_W_P-1:0] wdata_i,
  output logic [NIB_W_P-1:0]  rdata_o,
  output logic                rd_oe_o
);
  localparam int SEL_W = $clog2(NUM_REGS_P);

  logic                                in_win;
  logic [SEL_W-1:0]                    sel;
  logic                                m2_fall;
  logic                                wr_en;
  logic [NUM_REGS_P-1:0]               we_vec;
  logic [NUM_REGS_P-1:0][NIB_W_P-1:0]  regs;
  logic                                unused_hi;

  nib_win_dec #(
    .ADDR_W(ADDR_W_P), .WIN_LOG2(WIN_LOG2_P), .SEL_W(SEL_W), .WIN_BASE(WIN_BASE_P)
  ) u_dec (
    .addr_i(addr_i), .in_win_o(in_win), .sel_o(sel)
  );

  nib_m2_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .m2_i(m2_i), .fall_o(m2_fall)
  );

  assign wr_en = m2_fall & ~rw_i & in_win & con_rst_ni;

  for (genvar g = 0; g < NUM_REGS_P; g++) begin : g_we
    assign we_vec[g] = wr_en && (sel == SEL_W'(g));
  end

  nib_bank #(
    .NUM_REGS(NUM_REGS_P), .NIB_W(NIB_W_P), .INIT_VAL('1)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_vec),
    .wdata_i(wdata_i[NIB_W_P-1:0]), .q_o(regs)
  );

  assign rd_oe_o   = m2_i & rw_i & in_win & con_rst_ni;
  assign rdata_o   = rd_oe_o ? regs[sel] : '0;
  assign unused_hi = ^wdata_i[DATA_W_P-1:NIB_W_P];

  assert_oe_read_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> (rw_i && m2_i && addr_i[ADDR_W_P-1:WIN_LOG2_P] == WIN_BASE_P[ADDR_W_P-1:WIN_LOG2_P]));

  assert_console_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !con_rst_ni |=> $stable(regs));

  assert_console_no_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !con_rst_ni |-> !rd_oe_o);
endmodule

// File: tb/nib_scratch_test.sv
module nib_scratch_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        con_rst_ni = 1'b1;
  logic        m2_i = 1'b0;
  logic        rw_i = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [3:0]  rdata_o;
  logic        rd_oe_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  nib_scratch uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .con_rst_ni(con_rst_ni), .m2_i(m2_i),
    .rw_i(rw_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rd_oe_o(rd_oe_o)
  );

  // {write addr, write data, read addr, expected nibble}
  localparam int NVEC = 8;
  localparam logic [43:0] VEC [NVEC] = '{
    {16'h5800, 8'hF6, 16'h5800, 4'h6},  // R3 upper bits dropped
    {16'h5801, 8'hA9, 16'h5FFD, 4'h9},  // R2 alias read
    {16'h5DCB, 8'h0C, 16'h5803, 4'hC},  // R2 mid bits ignored
    {16'h5FFE, 8'h35, 16'h5802, 4'h5},  // R2 top of window
    {16'h57FF, 8'h00, 16'h5FFF, 4'hC},  // R1 below window
    {16'h6000, 8'h01, 16'h5804, 4'h6},  // R1 above window
    {16'h5C04, 8'h8A, 16'h5800, 4'hA},  // R3 overwrite
    {16'h5BF9, 8'h72, 16'h5801, 4'h2}   // R3 overwrite
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; rw_i = 1'b0; m2_i = 1'b1;
    @(negedge clk_i);
    m2_i = 1'b0;
    @(negedge clk_i);
    rw_i = 1'b1;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [3:0] d, output logic oe);
    @(negedge clk_i);
    addr_i = a; rw_i = 1'b1; m2_i = 1'b1;
    #1;
    d = rdata_o; oe = rd_oe_o;
    @(negedge clk_i);
    m2_i = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [3:0] exp);
    logic [3:0] d;
    logic oe;
    bus_read(a, d, oe);
    chk(req, {3'b0, oe}, 4'h1);
    chk(req, d, exp);
  endtask

  initial begin
    #(CLK_P*100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic oe;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R6 power-on state, R2 all four selected
    for (int r = 0; r < 4; r++) read_chk("R6 init", 16'h5800 + 16'(r), 4'hF);

    // R5 idle: no oe, zero data
    #1;
    chk("R5 idle oe", {3'b0, rd_oe_o}, 4'h0);
    chk("R5 idle data", rdata_o, 4'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][43:28], VEC[i][27:20]);
      read_chk("R1/R2/R3 table", VEC[i][19:4], VEC[i][3:0]);
    end
    // regs now: r0=A r1=2 r2=5 r3=C

    // R1 read outside window
    bus_read(16'h57FC, d, oe);
    chk("R1 read outside oe", {3'b0, oe}, 4'h0);
    chk("R1 read outside data", d, 4'h0);

    // R5 write cycle, m2 high: no oe
    @(negedge clk_i);
    addr_i = 16'h5800; rw_i = 1'b0; m2_i = 1'b1; #1;
    chk("R5 oe during write", {3'b0, rd_oe_o}, 4'h0);
    // R4 hold m2 high several cycles, then flip to read before fall
    wdata_i = 8'h03; addr_i = 16'h5802;
    repeat (3) @(negedge clk_i);
    rw_i = 1'b1;
    @(negedge clk_i);
    m2_i = 1'b0;
    @(negedge clk_i);
    read_chk("R4 no write without rw low at fall", 16'h5802, 4'h5);

    // R5 m2 low with read address: no oe
    @(negedge clk_i);
    addr_i = 16'h5803; rw_i = 1'b1; m2_i = 1'b0; #1;
    chk("R5 m2 low oe", {3'b0, rd_oe_o}, 4'h0);

    // R8 repeated reads
    read_chk("R8 read 1", 16'h5FFF, 4'hC);
    read_chk("R8 read 2", 16'h5BB3, 4'hC);

    // R7 console reset: writes blocked, oe low, contents kept
    @(negedge clk_i);
    con_rst_ni = 1'b0;
    bus_write(16'h5800, 8'h00);
    bus_read(16'h5800, d, oe);
    chk("R7 oe during console reset", {3'b0, oe}, 4'h0);
    @(negedge clk_i);
    con_rst_ni = 1'b1;
    read_chk("R7 kept r0", 16'h5800, 4'hA);
    read_chk("R7 kept r1", 16'h5801, 4'h2);
    read_chk("R7 kept r2", 16'h5802, 4'h5);
    read_chk("R7 kept r3", 16'h5803, 4'hC);

    // R6 power-on reset again restores $F
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int r = 0; r < 4; r++) read_chk("R6 re-init", 16'h5FFC + 16'(r), 4'hF);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule